// File: doc/BRIEF.md
# Interrupt Status and Clear-on-Read Unit

This block gathers the twelve interrupt sources of a two-wire serial bus controller and turns them into one registered interrupt line. Ten of the sources are events: a one-cycle pulse sets a sticky bit, and software clears it later. The other two are levels. The receive-full level compares the receive FIFO fill level against a programmable threshold. The transmit-empty level compares the transmit FIFO fill level against a second threshold. The FIFOs are outside the block, and only their fill levels come in.

Software works through a simple word-addressed register port. It can write an enable mask, read the raw source vector, read the masked vector and set the two thresholds. Events are cleared as a side effect of reading. One address clears every sticky event at once. A separate address exists for each sticky source and clears that source alone. A read at either kind of clear address returns whether something was pending before the clear.

Top module: `irq_status_unit`

## Requirements
- R1: After a synchronous active-low reset: the mask, both thresholds and all sticky events are zero, and `irq` is low.
- R2: Source bit positions: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. The mask and both status words use these positions.
- R3: A high bit of `evt_in` at a clock edge sets the matching sticky event, for every position except 2 and 4. `evt_in` bits 2 and 4 have no effect.
- R4: If an event pulse arrives in the same cycle as a clearing read of that event, the event stays set.
- R5: A read at address 8+k clears sticky event k only, for k in {0,1,3,5..11}. Bit 0 of the read data is the value of event k before the clear. Reads at address 10 and address 12 return 0 and clear nothing.
- R6: A read at address 5 clears all sticky events. Bit 0 of the read data is 1 if any sticky event was set.
- R7: Raw bit 2 is 1 while `rx_level` is strictly greater than the receive threshold (address 3). This bit is not sticky, and clearing reads do not affect it.
- R8: Raw bit 4 is 1 while `tx_level` is less than or equal to the transmit threshold (address 4). This bit is not sticky, and clearing reads do not affect it.
- R9: A read at address 1 returns the raw source vector. A read at address 2 returns the raw vector ANDed with the mask. A read at address 0 returns the mask.
- R10: After each clock edge, `irq` is the OR over all sources of (the mask after that edge) AND (the sticky event after that edge, or the level bit as it stood before the edge). A write of zero to the mask therefore makes `irq` low after that same edge.
- R11: Writes take effect only at address 0 (12-bit mask), address 3 and address 4 (thresholds). Reads at any unmapped address, and `rd_data` whenever no read is presented, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 12 | Event pulses, one per source position |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, combinational on the presented access |
| irq | output | 1 | Registered interrupt line |

## Verification
The checks assume that every bus access lasts exactly one cycle. They also assume that a read is a single cycle in which `bus_sel` is high and `bus_wr` is low, so each such cycle counts as one clearing read. The assertions further assume that the FIFO levels never exceed the FIFO depth. The stimulus drives only single-cycle accesses and keeps both levels within 0 to 16. It also sends event pulses of arbitrary width, including pulses on the level positions, which the design must ignore. Clearing reads are placed deliberately in the same cycle as event pulses on the same source.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt status unit.
// Assumes a 12-source layout; bit positions are fixed by the register view.
package irq_pkg;
    localparam int NSRC = 12;

    localparam int EV_RX_UNDER = 0;
    localparam int EV_RX_OVER  = 1;
    localparam int EV_RX_FULL  = 2;
    localparam int EV_TX_OVER  = 3;
    localparam int EV_TX_EMPTY = 4;
    localparam int EV_RD_REQ   = 5;
    localparam int EV_TX_ABORT = 6;
    localparam int EV_RX_DONE  = 7;
    localparam int EV_ACTIVITY = 8;
    localparam int EV_STOP     = 9;
    localparam int EV_START    = 10;
    localparam int EV_GCALL    = 11;

    // Sources that latch and can be cleared (all except the two levels).
    localparam logic [NSRC-1:0] STICKY_MASK =
        ~((NSRC'(1) << EV_RX_FULL) | (NSRC'(1) << EV_TX_EMPTY));

    // Word addresses.
    localparam int A_MASK    = 0;
    localparam int A_RAW     = 1;
    localparam int A_MSTAT   = 2;
    localparam int A_RX_THR  = 3;
    localparam int A_TX_THR  = 4;
    localparam int A_CLR_ALL = 5;
    localparam int A_CLR_ONE = 8;
endpackage

// File: rtl/irq_level_cmp.sv
// Module: threshold comparator for one FIFO level source.
// ABOVE=1 gives level > thr, ABOVE=0 gives level <= thr.
// Assumes level and thr are unsigned and share a width.
module irq_level_cmp #(
    parameter int LVL_W = 5,
    parameter bit ABOVE = 1'b1
) (
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] thr,
    output logic             hit
);
    generate
        if (ABOVE) begin : g_above
            // Fill-up condition: strictly more entries than the threshold.
            always_comb hit = (level > thr);
        end else begin : g_below
            // Drain condition: entries at or under the threshold.
            always_comb hit = (level <= thr);
        end
    endgenerate
endmodule

// File: rtl/irq_event_latch.sv
// Module: sticky event bits with set-over-clear priority.
// Only positions flagged in STICKY_MASK hold state; other positions read 0.
// Assumes set_in and clr_in are sampled on the same edge.
module irq_event_latch
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_in,
    input  logic [NSRC-1:0] clr_in,
    output logic [NSRC-1:0] lat_q,
    output logic [NSRC-1:0] lat_nxt
);
    genvar i;
    generate
        for (i = 0; i < NSRC; i++) begin : g_bit
            if (STICKY_MASK[i]) begin : g_sticky
                // Next value: a new event wins over a clear in the same cycle.
                always_comb lat_nxt[i] = set_in[i] | (lat_q[i] & ~clr_in[i]);

                // State flop for one sticky event.
                always_ff @(posedge clk) begin
                    if (!rst_n) lat_q[i] <= 1'b0;
                    else        lat_q[i] <= lat_nxt[i];
                end

                // R4: an event pulse is never lost to a concurrent clear.
                a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                    set_in[i] |=> lat_q[i]);
                // R5: a clear with no new pulse empties the bit.
                a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_in[i] && !set_in[i]) |=> !lat_q[i]);
            end else begin : g_level
                // Level positions hold no state.
                always_comb lat_nxt[i] = 1'b0;
                always_comb lat_q[i]   = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_bus_decode.sv
// Module: register port decode: holds mask and thresholds, produces clear strobes.
// Assumes each access is a single-cycle strobe; a read cycle is one clearing read.
module irq_bus_decode
    import irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NSRC-1:0]   mask_q,
    output logic [NSRC-1:0]   mask_nxt,
    output logic [LVL_W-1:0]  rx_thr_q,
    output logic [LVL_W-1:0]  tx_thr_q,
    output logic [NSRC-1:0]   clr_vec,
    output logic              rd_en
);
    logic wr_en;
    logic [LVL_W-1:0] rx_thr_nxt;
    logic [LVL_W-1:0] tx_thr_nxt;

    // Split the strobe into read and write.
    always_comb begin
        rd_en = bus_sel & ~bus_wr;
        wr_en = bus_sel &  bus_wr;
    end

    // Next values of the writable registers.
    always_comb begin
        mask_nxt   = mask_q;
        rx_thr_nxt = rx_thr_q;
        tx_thr_nxt = tx_thr_q;
        if (wr_en) begin
            if (bus_addr == ADDR_W'(A_MASK))   mask_nxt   = bus_wdata[NSRC-1:0];
            if (bus_addr == ADDR_W'(A_RX_THR)) rx_thr_nxt = bus_wdata[LVL_W-1:0];
            if (bus_addr == ADDR_W'(A_TX_THR)) tx_thr_nxt = bus_wdata[LVL_W-1:0];
        end
    end

    // Writable register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q   <= '0;
            rx_thr_q <= '0;
            tx_thr_q <= '0;
        end else begin
            mask_q   <= mask_nxt;
            rx_thr_q <= rx_thr_nxt;
            tx_thr_q <= tx_thr_nxt;
        end
    end

    // Clear strobes: the combined address clears all sticky bits, per-source addresses one each.
    always_comb begin
        clr_vec = '0;
        if (rd_en && bus_addr == ADDR_W'(A_CLR_ALL)) clr_vec = STICKY_MASK;
        for (int k = 0; k < NSRC; k++) begin
            if (rd_en && STICKY_MASK[k] && bus_addr == ADDR_W'(A_CLR_ONE + k))
                clr_vec[k] = 1'b1;
        end
    end

    // R11: a write only lands at its own address.
    a_r11_mask_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == ADDR_W'(A_MASK)) |=> $stable(mask_q));
endmodule

// File: rtl/irq_status_unit.sv
// Module: top of the interrupt status unit. Combines sticky events and FIFO
// level sources, applies the mask, serves reads and drives a registered irq.
// Assumes DATA_W >= 12 and DATA_W >= LVL_W; levels never exceed FIFO_DEPTH.
module irq_status_unit
    import irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   evt_in,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [NSRC-1:0]  mask_q, mask_nxt, clr_vec, lat_q, lat_nxt, set_vec;
    logic [NSRC-1:0]  lvl_vec, raw_vec;
    logic [LVL_W-1:0] rx_thr_q, tx_thr_q;
    logic             rd_en, rx_hit, tx_hit;

    irq_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) i_decode (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mask_q(mask_q),
        .mask_nxt(mask_nxt), .rx_thr_q(rx_thr_q), .tx_thr_q(tx_thr_q),
        .clr_vec(clr_vec), .rd_en(rd_en)
    );

    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b1)) i_rx_cmp (
        .level(rx_level), .thr(rx_thr_q), .hit(rx_hit)
    );
    irq_level_cmp #(.LVL_W(LVL_W), .ABOVE(1'b0)) i_tx_cmp (
        .level(tx_level), .thr(tx_thr_q), .hit(tx_hit)
    );

    // Only sticky positions accept pulses.
    always_comb set_vec = evt_in & STICKY_MASK;

    irq_event_latch i_latch (
        .clk(clk), .rst_n(rst_n), .set_in(set_vec), .clr_in(clr_vec),
        .lat_q(lat_q), .lat_nxt(lat_nxt)
    );

    // Assemble the raw vector from sticky bits and the two level sources.
    always_comb begin
        lvl_vec = '0;
        lvl_vec[EV_RX_FULL]  = rx_hit;
        lvl_vec[EV_TX_EMPTY] = tx_hit;
        raw_vec = lat_q | lvl_vec;
    end

    // Read mux; zero when no read is presented or the address is unmapped.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (bus_addr == ADDR_W'(A_MASK))    rd_data = DATA_W'(mask_q);
            if (bus_addr == ADDR_W'(A_RAW))     rd_data = DATA_W'(raw_vec);
            if (bus_addr == ADDR_W'(A_MSTAT))   rd_data = DATA_W'(raw_vec & mask_q);
            if (bus_addr == ADDR_W'(A_RX_THR))  rd_data = DATA_W'(rx_thr_q);
            if (bus_addr == ADDR_W'(A_TX_THR))  rd_data = DATA_W'(tx_thr_q);
            if (bus_addr == ADDR_W'(A_CLR_ALL)) rd_data = DATA_W'(|lat_q);
            for (int k = 0; k < NSRC; k++) begin
                if (STICKY_MASK[k] && bus_addr == ADDR_W'(A_CLR_ONE + k))
                    rd_data = DATA_W'(lat_q[k]);
            end
        end
    end

    // Registered interrupt line, aligned with the mask and sticky state after the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |((lat_nxt | lvl_vec) & mask_nxt);
    end

    // R10: an all-zero mask keeps the line quiet.
    a_r10_mask_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    // R6: the combined clear with no new pulse leaves no sticky bit in the raw view.
    a_r6_clear_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == ADDR_W'(A_CLR_ALL) && set_vec == '0)
        |=> ((raw_vec & STICKY_MASK) == '0));
    // R7: the receive-full bit tracks the level, not the clear reads.
    a_r7_full_not_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= rx_thr_q) |-> !raw_vec[EV_RX_FULL]);
    // R8: the transmit-empty bit is high whenever the level is at zero.
    a_r8_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == '0) |-> raw_vec[EV_TX_EMPTY]);
endmodule

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int LW = 5;
    localparam logic [11:0] STICKY = 12'hFEB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [11:0]   evt_in = '0;
    logic [LW-1:0] rx_level = '0, tx_level = '0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state.
    logic [11:0] m_mask = '0, m_lat = '0;
    int          m_rthr = 0, m_tthr = 0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .rx_level(rx_level),
        .tx_level(tx_level), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [11:0] m_levels(int rl, int tl);
        logic [11:0] v = '0;
        v[2] = (rl > m_rthr);
        v[4] = (tl <= m_tthr);
        return v;
    endfunction

    function automatic logic [15:0] m_read(int a, int rl, int tl);
        logic [11:0] raw = m_lat | m_levels(rl, tl);
        case (a)
            0: return {4'h0, m_mask};
            1: return {4'h0, raw};
            2: return {4'h0, raw & m_mask};
            3: return 16'(m_rthr);
            4: return 16'(m_tthr);
            5: return {15'h0, |m_lat};
            default: begin
                if (a >= 8 && a < 20 && STICKY[a-8]) return {15'h0, m_lat[a-8]};
                return 16'h0;
            end
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive, check read data, advance the model, check irq.
    task automatic cyc(logic s, logic w, int a, logic [15:0] d, logic [11:0] e,
                       int rl, int tl, string tag);
        logic [11:0] lv;
        logic [11:0] clr;
        bus_sel = s; bus_wr = w; bus_addr = AW'(a); bus_wdata = d;
        evt_in = e; rx_level = LW'(rl); tx_level = LW'(tl);
        #1;
        check(tag, (s && !w) ? rd_data : 16'h0, (s && !w) ? m_read(a, rl, tl) : 16'h0);
        lv = m_levels(rl, tl);
        clr = '0;
        if (s && !w && a == 5) clr = STICKY;
        if (s && !w && a >= 8 && a < 20 && STICKY[a-8]) clr[a-8] = 1'b1;
        @(posedge clk);
        if (s && w && a == 0) m_mask = d[11:0];
        if (s && w && a == 3) m_rthr = int'(d[LW-1:0]);
        if (s && w && a == 4) m_tthr = int'(d[LW-1:0]);
        m_lat = (m_lat & ~clr) | (e & STICKY);
        m_irq = |((m_lat | lv) & m_mask);
        @(negedge clk);
        check({tag, " irq"}, {15'h0, irq}, {15'h0, m_irq});
    endtask

    task automatic rd(int a, int rl, int tl, string tag);
        cyc(1'b1, 1'b0, a, 16'h0, 12'h0, rl, tl, tag);
    endtask

    task automatic wr(int a, logic [15:0] d, int rl, int tl, string tag);
        cyc(1'b1, 1'b1, a, d, 12'h0, rl, tl, tag);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {15'h0, irq}, 16'h0);
        rd(0, 0, 0, "R1 mask reset");
        rd(1, 0, 0, "R1 raw reset");
        rd(3, 0, 0, "R1 rx thr reset");

        // R3: pulse every source including the level positions.
        cyc(1'b0, 1'b0, 0, 0, 12'hFFF, 0, 5, "R3 pulse all");
        rd(1, 0, 5, "R3 R2 raw after pulse");
        wr(0, 16'h0FFF, 0, 5, "R10 unmask all");
        rd(2, 0, 5, "R9 masked status");

        // R5: single clears.
        rd(9, 0, 5, "R5 clear rx overflow");
        rd(9, 0, 5, "R5 second clear returns 0");
        rd(10, 0, 5, "R5 addr 10 no effect");
        rd(1, 0, 5, "R5 raw after single clear");

        // R4: clearing read and pulse on the same source in one cycle.
        cyc(1'b1, 1'b0, 14, 0, 12'h040, 0, 5, "R4 clear with pulse");
        rd(14, 0, 5, "R4 event survived");

        // R6: clear all.
        rd(5, 0, 5, "R6 clear all");
        rd(1, 0, 5, "R6 raw after clear all");
        rd(5, 0, 5, "R6 clear all empty");

        // R7: rx threshold.
        wr(3, 16'd3, 3, 5, "R7 set rx thr");
        rd(1, 3, 5, "R7 level equal");
        rd(1, 4, 5, "R7 level above");
        rd(5, 4, 5, "R7 clear all while full");
        rd(10, 4, 5, "R7 rx full clear addr");
        rd(1, 4, 5, "R7 still full");

        // R8: tx threshold.
        wr(4, 16'd6, 4, 7, "R8 set tx thr");
        rd(1, 4, 7, "R8 level above thr");
        rd(1, 4, 6, "R8 level at thr");
        rd(12, 4, 6, "R8 tx empty clear addr");
        rd(1, 4, 6, "R8 still empty");

        // R10: mask to zero drops irq after the write edge.
        wr(0, 16'h0000, 4, 6, "R10 mask zero");
        wr(0, 16'h0004, 4, 6, "R10 mask rx full");
        wr(0, 16'h0000, 4, 6, "R10 mask zero again");

        // R11: unmapped writes and reads.
        wr(6, 16'hFFFF, 4, 6, "R11 write unmapped");
        wr(1, 16'hFFFF, 4, 6, "R11 write raw addr");
        rd(6, 4, 6, "R11 read unmapped");
        rd(0, 4, 6, "R11 mask unchanged");
        rd(31, 4, 6, "R11 read high unmapped");

        // Random traffic compared every clock.
        for (int i = 0; i < 3000; i++) begin
            logic s, w;
            int a;
            logic [15:0] d;
            logic [11:0] e;
            s = ($urandom % 3) != 0;
            w = ($urandom % 4) == 0;
            a = int'($urandom % 22);
            d = 16'($urandom);
            if (a == 3 || a == 4) d = 16'($urandom % 17);
            e = (($urandom % 6) == 0) ? 12'($urandom) : 12'h0;
            cyc(s, w, a, d, e, int'($urandom % 17), int'($urandom % 17), "R10 R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule